// File: doc/BRIEF.md
# Per-thread return address stack

This block predicts where a subroutine return will land. Every hardware thread keeps its own last-in, first-out stack of return addresses. A call pushes the address that follows it onto the calling thread's stack. A return pops that thread's most recent address as the predicted target, together with a flag that says whether the prediction is valid. Indirect branches that are not returns take no part in this block.

All stacks share one pool of 32 entries, and the multithreading mode divides that pool among the running threads:

| Mode | Active threads | Depth per thread | Slices of the pool |
|------|----------------|------------------|--------------------|
| single thread | thread 0 | 16 | thread 0: entries 0..15 |
| two threads | threads 0 and 1 | 16 | thread t: entries 16t..16t+15 |
| four threads | threads 0 to 3 | 8 | thread t: entries 8t..8t+7 |

Each thread's stack is circular inside its slice. When the stack is full, a new push overwrites the oldest entry. The block can clear a single thread's stack with that thread's flush input, and it clears every stack when the mode changes.

Top module: `ret_stack`

## Requirements
- R1: After reset every stack is empty and the mode register holds single-thread mode. A pop returns `pop_valid_o`=0 and `pop_addr_o`=0.
- R2: A pop returns, in the same cycle, the most recent address pushed to that thread that has not yet been popped. The pop removes that address.
- R3: Each thread's stack is independent. A push, pop, overflow or flush on one thread never changes what another thread's pops return. A push on one thread and a pop on another thread may happen in the same cycle.
- R4: In single-thread and two-thread mode a thread holds 16 entries. After 17 pushes, 16 pops return the newest 16 addresses, and the next pop is invalid.
- R5: In four-thread mode a thread holds 8 entries. After 9 pushes, 8 pops return the newest 8 addresses, and the next pop is invalid.
- R6: A pop from an empty stack returns valid 0 and address 0, and the stack pointer does not move. `pop_valid_o` is never 1 unless `pop_i` is 1.
- R7: When `flush_i[t]` is 1, thread t's stack is empty from the next cycle on. The other threads keep their stacks.
- R8: When `mode_i` differs from the registered mode, every stack is empty from the next cycle on. In that cycle all pushes and pops are ignored and the pop result is invalid.
- R9: A push and a pop to the same non-empty thread in the same cycle return the current top and then replace it with the pushed address. The entry count does not change. If the thread is empty, the pop is invalid and the push proceeds.
- R10: A push or pop to a thread that the current mode does not run is ignored. The pop returns valid 0, and the stacks of the active threads stay intact.
- R11: A flush of thread t takes precedence over a push or pop to thread t in the same cycle. The push is dropped and the pop is invalid.
- R12: The mode is encoded on `mode_i` as 2'b00 for single thread, 2'b01 for two threads, and 2'b10 or 2'b11 for four threads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Multithreading mode |
| flush_i | input | 4 | Per-thread clear, one bit per thread |
| push_i | input | 1 | Push request (call) |
| push_tid_i | input | 2 | Thread of the push |
| push_addr_i | input | ADDR_W | Return address to store |
| pop_i | input | 1 | Pop request (return) |
| pop_tid_i | input | 2 | Thread of the pop |
| pop_valid_o | output | 1 | Predicted address is valid |
| pop_addr_o | output | ADDR_W | Predicted return address, 0 when not valid |

## Verification
Two operations can fall in the same cycle on one thread: a push and a pop, or a flush together with a push. The bench drives both pairs on purpose. First it drives a push and a pop to one thread whose stack holds one entry, and checks that the pop returns the old top. Then it pops again and expects the pushed address, and pops a third time and expects an invalid result. That shows the slot was replaced and the entry count stayed the same. The same sequence is also run with the thread empty. The flush-and-push pair is judged by the next pop to that thread, which must be invalid. A push to one thread paired with a pop from another must leave both stacks correct.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int unsigned NUM_THREADS = 4;
  localparam int unsigned TID_W       = 2;

  typedef enum logic [1:0] {
    MODE_ONE      = 2'b00,
    MODE_TWO      = 2'b01,
    MODE_FOUR     = 2'b10,
    MODE_FOUR_ALT = 2'b11
  } rs_mode_e;
endpackage

// File: rtl/rs_partition.sv
module rs_partition
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH_MIN = 8,
  localparam int unsigned DEPTH_MAX = 2 * DEPTH_MIN,
  localparam int unsigned ENTRIES   = DEPTH_MIN * NUM_THREADS,
  localparam int unsigned IDX_W     = $clog2(ENTRIES),
  localparam int unsigned CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input  rs_mode_e                             mode_i,
  output logic [NUM_THREADS-1:0]               active_o,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]    depth_o,
  output logic [NUM_THREADS-1:0][IDX_W-1:0]    base_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      case (mode_i)
        MODE_ONE: begin
          active_o[t] = (t == 0);
          depth_o[t]  = CNT_W'(DEPTH_MAX);
          base_o[t]   = '0;
        end
        MODE_TWO: begin
          active_o[t] = (t < 2);
          depth_o[t]  = CNT_W'(DEPTH_MAX);
          base_o[t]   = IDX_W'((t % 2) * DEPTH_MAX);
        end
        default: begin
          active_o[t] = 1'b1;
          depth_o[t]  = CNT_W'(DEPTH_MIN);
          base_o[t]   = IDX_W'(t * DEPTH_MIN);
        end
      endcase
    end
  end
endmodule

// File: rtl/rs_thread_ctrl.sv
module rs_thread_ctrl #(
  parameter int unsigned DEPTH_MIN = 8,
  localparam int unsigned DEPTH_MAX = 2 * DEPTH_MIN,
  localparam int unsigned PTR_W     = $clog2(DEPTH_MAX),
  localparam int unsigned CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] depth_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic [PTR_W-1:0] top_slot_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt, ptr_top;
  logic [CNT_W-1:0] cnt_q, ptr_inc;
  logic             empty, replace;

  // ptr_q is the next free slot; top is one below it, circular in depth
  assign ptr_inc = CNT_W'(ptr_q) + CNT_W'(1);
  assign ptr_nxt = (ptr_inc == depth_i) ? '0 : ptr_inc[PTR_W-1:0];
  assign ptr_top = (ptr_q == '0) ? PTR_W'(depth_i - CNT_W'(1)) : ptr_q - PTR_W'(1);
  assign empty   = (cnt_q == '0);
  assign replace = push_i && pop_i && !empty;

  assign wr_slot_o  = replace ? ptr_top : ptr_q;
  assign top_slot_o = ptr_top;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (replace) begin
      ptr_q <= ptr_q;
    end else if (push_i) begin
      ptr_q <= ptr_nxt;
      if (cnt_q != depth_i) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty) begin
      ptr_q <= ptr_top;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rs_storage.sv
module rs_storage #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEPTH_MIN = 8,
  localparam int unsigned DEPTH_MAX = 2 * DEPTH_MIN,
  localparam int unsigned ENTRIES   = DEPTH_MIN * NUM_THREADS,
  localparam int unsigned IDX_W     = $clog2(ENTRIES),
  localparam int unsigned PTR_W     = $clog2(DEPTH_MAX),
  localparam int unsigned CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             mode_i,
  input  logic [NUM_THREADS-1:0] flush_i,
  input  logic                   push_i,
  input  logic [TID_W-1:0]       push_tid_i,
  input  logic [ADDR_W-1:0]      push_addr_i,
  input  logic                   pop_i,
  input  logic [TID_W-1:0]       pop_tid_i,
  output logic                   pop_valid_o,
  output logic [ADDR_W-1:0]      pop_addr_o
);
  rs_mode_e                          mode_q;
  logic                              mode_chg;
  logic [NUM_THREADS-1:0]            active_w;
  logic [NUM_THREADS-1:0][CNT_W-1:0] depth_w;
  logic [NUM_THREADS-1:0][IDX_W-1:0] base_w;
  logic [NUM_THREADS-1:0][PTR_W-1:0] wr_slot_w, top_slot_w;
  logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_THREADS-1:0]            th_push, th_pop, th_clear;
  logic                              push_ok, pop_ok;
  logic [IDX_W-1:0]                  waddr, raddr;
  logic [ADDR_W-1:0]                 rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ONE;
    else         mode_q <= rs_mode_e'(mode_i);
  end

  assign mode_chg = (mode_i != mode_q);

  rs_partition #(.DEPTH_MIN(DEPTH_MIN)) u_part (
    .mode_i   (mode_q),
    .active_o (active_w),
    .depth_o  (depth_w),
    .base_o   (base_w)
  );

  // flush and mode change dominate any same-cycle operation
  assign push_ok = push_i && active_w[push_tid_i] && !mode_chg && !flush_i[push_tid_i];
  assign pop_ok  = pop_i  && active_w[pop_tid_i]  && !mode_chg && !flush_i[pop_tid_i];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign th_push[t]  = push_ok && (push_tid_i == TID_W'(t));
    assign th_pop[t]   = pop_ok  && (pop_tid_i  == TID_W'(t));
    assign th_clear[t] = flush_i[t] || mode_chg;

    rs_thread_ctrl #(.DEPTH_MIN(DEPTH_MIN)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (th_clear[t]),
      .depth_i    (depth_w[t]),
      .push_i     (th_push[t]),
      .pop_i      (th_pop[t]),
      .wr_slot_o  (wr_slot_w[t]),
      .top_slot_o (top_slot_w[t]),
      .cnt_o      (cnt_w[t])
    );
  end

  assign waddr = base_w[push_tid_i] + IDX_W'(wr_slot_w[push_tid_i]);
  assign raddr = base_w[pop_tid_i]  + IDX_W'(top_slot_w[pop_tid_i]);

  rs_storage #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .waddr_i (waddr),
    .wdata_i (push_addr_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign pop_valid_o = pop_ok && (cnt_w[pop_tid_i] != '0);
  assign pop_addr_o  = pop_valid_o ? rdata : '0;
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH_MIN = 8,
  localparam int unsigned DEPTH_MAX = 2 * DEPTH_MIN,
  localparam int unsigned CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [1:0]                        mode_i,
  input logic [1:0]                        mode_q_i,
  input logic [NUM_THREADS-1:0]            flush_i,
  input logic                              push_i,
  input logic [TID_W-1:0]                  push_tid_i,
  input logic                              pop_i,
  input logic [TID_W-1:0]                  pop_tid_i,
  input logic                              pop_valid_i,
  input logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_i
);
  assert_pop_needs_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_i |-> (pop_i && cnt_i[pop_tid_i] != '0));

  assert_mode_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q_i) |=> (cnt_i == '0));

  assert_inactive_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q_i == 2'b00 && pop_tid_i != '0) || (mode_q_i == 2'b01 && pop_tid_i[1]))
      |-> !pop_valid_i);

  assert_replace_keeps_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && push_tid_i == '0 && pop_tid_i == '0 && cnt_i[0] != '0
     && !flush_i[0] && mode_i == mode_q_i) |=> $stable(cnt_i[0]));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[t] <= CNT_W'(DEPTH_MAX));

    assert_count_bound_four_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q_i[1] |-> (cnt_i[t] <= CNT_W'(DEPTH_MIN)));

    assert_flush_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> (cnt_i[t] == '0));
  end
endmodule

bind ret_stack ret_stack_chk #(.DEPTH_MIN(DEPTH_MIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .mode_q_i    (mode_q),
  .flush_i     (flush_i),
  .push_i      (push_i),
  .push_tid_i  (push_tid_i),
  .pop_i       (pop_i),
  .pop_tid_i   (pop_tid_i),
  .pop_valid_i (pop_valid_o),
  .cnt_i       (cnt_w)
);

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  flush_i = '0;
  logic        push_i = 1'b0;
  logic [1:0]  push_tid_i = '0;
  logic [31:0] push_addr_i = '0;
  logic        pop_i = 1'b0;
  logic [1:0]  pop_tid_i = '0;
  logic        pop_valid_o;
  logic [31:0] pop_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  ret_stack u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        push;
    logic [1:0]  ptid;
    logic [31:0] paddr;
    logic        pop;
    logic [1:0]  otid;
    logic [3:0]  flush;
    logic        ev;
    logic [31:0] ea;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd8},  // R8 enter two-thread
    '{2'd1, 1'b1, 2'd0, 32'hA000_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd2},
    '{2'd1, 1'b1, 2'd0, 32'hA000_0002, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd2},
    '{2'd1, 1'b1, 2'd1, 32'hB000_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd3},
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b1, 32'hA000_0002, 8'd2},  // R2
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 4'h0, 1'b1, 32'hB000_0001, 8'd3},  // R3
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 4'h0, 1'b0, 32'h0,         8'd6},  // R6 empty
    '{2'd1, 1'b1, 2'd1, 32'hB000_0002, 1'b1, 2'd0, 4'h0, 1'b1, 32'hA000_0001, 8'd3},  // R3 cross-thread
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 4'h0, 1'b1, 32'hB000_0002, 8'd6},  // R6 ptr kept
    '{2'd1, 1'b1, 2'd0, 32'hC000_0001, 1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd9},  // R9 empty
    '{2'd1, 1'b1, 2'd0, 32'hC000_0002, 1'b1, 2'd0, 4'h0, 1'b1, 32'hC000_0001, 8'd9},  // R9 replace
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b1, 32'hC000_0002, 8'd9},
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd9},
    '{2'd1, 1'b1, 2'd0, 32'hD000_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd7},
    '{2'd1, 1'b1, 2'd1, 32'hE000_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd7},
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 4'h1, 1'b1, 32'hE000_0001, 8'd7},  // R7 other kept
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd7},  // R7 cleared
    '{2'd1, 1'b1, 2'd0, 32'hF000_0001, 1'b0, 2'd0, 4'h1, 1'b0, 32'h0,         8'd11}, // R11
    '{2'd1, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd11},
    '{2'd1, 1'b1, 2'd0, 32'h1000_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd8},
    '{2'd1, 1'b1, 2'd1, 32'h1100_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd8},
    '{2'd2, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd8},  // R8 change cycle
    '{2'd2, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd8},  // R8 cleared
    '{2'd2, 1'b1, 2'd3, 32'h3300_0003, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd12},
    '{2'd2, 1'b1, 2'd2, 32'h2200_0002, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd12},
    '{2'd2, 1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 4'h0, 1'b1, 32'h3300_0003, 8'd12}, // R12 10
    '{2'd3, 1'b0, 2'd0, 32'h0,         1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd12},
    '{2'd3, 1'b1, 2'd3, 32'h3300_0004, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd12},
    '{2'd3, 1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 4'h0, 1'b1, 32'h3300_0004, 8'd12}, // R12 11
    '{2'd0, 1'b0, 2'd0, 32'h0,         1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd12},
    '{2'd0, 1'b1, 2'd0, 32'h4400_0000, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd10},
    '{2'd0, 1'b1, 2'd1, 32'h5500_0001, 1'b0, 2'd0, 4'h0, 1'b0, 32'h0,         8'd10}, // R10 ignored
    '{2'd0, 1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 4'h0, 1'b0, 32'h0,         8'd10},
    '{2'd0, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b1, 32'h4400_0000, 8'd10},
    '{2'd0, 1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 4'h0, 1'b0, 32'h0,         8'd10}
  };

  task automatic check(input string req, input logic ev, input logic [31:0] ea);
    checks++;
    if (pop_valid_o !== ev || pop_addr_o !== ea) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, pop_valid_o, pop_addr_o, ev, ea);
    end
  endtask

  // drive after the falling edge, sample just before the rising edge
  task automatic step(input logic [1:0] m, input logic pu, input logic [1:0] pt,
                      input logic [31:0] pa, input logic po, input logic [1:0] ot,
                      input logic [3:0] fl, input string req, input logic ev,
                      input logic [31:0] ea);
    @(negedge clk_i);
    mode_i = m; push_i = pu; push_tid_i = pt; push_addr_i = pa;
    pop_i = po; pop_tid_i = ot; flush_i = fl;
    #4;
    check(req, ev, ea);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: valid=%0b addr=%h expected run to end", pop_valid_o, pop_addr_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: empty after reset in single-thread mode
    step(2'd0, 1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 4'h0, "R1", 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].mode, VEC[i].push, VEC[i].ptid, VEC[i].paddr, VEC[i].pop,
           VEC[i].otid, VEC[i].flush, $sformatf("R%0d vec %0d", VEC[i].req, i),
           VEC[i].ev, VEC[i].ea);
    end

    // R4: depth 16 in single-thread mode, oldest overwritten
    for (int i = 0; i < 17; i++)
      step(2'd0, 1'b1, 2'd0, 32'h100 + i, 1'b0, 2'd0, 4'h0, "R4", 1'b0, 32'h0);
    for (int i = 0; i < 16; i++)
      step(2'd0, 1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 4'h0, "R4", 1'b1, 32'h110 - i);
    step(2'd0, 1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 4'h0, "R4", 1'b0, 32'h0);

    // R5: depth 8 in four-thread mode; R3: neighbour untouched by overflow
    step(2'd2, 1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 4'h0, "R5", 1'b0, 32'h0);
    step(2'd2, 1'b1, 2'd1, 32'h300, 1'b0, 2'd0, 4'h0, "R3", 1'b0, 32'h0);
    for (int i = 0; i < 9; i++)
      step(2'd2, 1'b1, 2'd2, 32'h200 + i, 1'b0, 2'd0, 4'h0, "R5", 1'b0, 32'h0);
    for (int i = 0; i < 8; i++)
      step(2'd2, 1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 4'h0, "R5", 1'b1, 32'h208 - i);
    step(2'd2, 1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 4'h0, "R5", 1'b0, 32'h0);
    step(2'd2, 1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 4'h0, "R3", 1'b1, 32'h300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule